// File: doc/BRIEF.md
# MSI Capability and Message Generator

This block is the device-side half of message-signalled interrupts. It holds a 32-bit-address MSI capability structure that system software reads and writes over a plain configuration register port: a header word carrying the capability ID and the control fields, a message address, a message data word, and per-vector mask and pending words. Up to 32 internal interrupt event lines feed it. Each event that is allowed through becomes one DWORD memory write of the message data to the programmed address, issued on a valid/ready write-request port.

Every event first latches a pending bit for its vector. A pending vector is served once MSI is enabled, its mask bit is clear and its index falls inside the enabled vector count. The message data sent for vector v has its low x bits replaced by v, where 2^x is the enabled count. Pending vectors are served one at a time, lowest index first. The mask, pending and data folding rules let software hold an interrupt back and release it later without losing it.

Top module: `msi_gen`

## Requirements
- R1: Configuration dword 0 reads as follows. Bits 7:0 hold 0x05. Bits 15:8 hold the next pointer (parameter, default 0x00). Bit 16 is the enable. Bits 19:17 hold the requested exponent (parameter, default 5). Bits 22:20 hold the enabled exponent. Bit 23 reads 0. Bit 24 reads 1 when per-vector masking is built in (default). Bits 31:25 read 0. After reset the enable and the enabled exponent are 0, and with the defaults the word reads 0x010A0005.
- R2: A write to dword 0 stores bit 16 as the enable and bits 22:20 as the enabled exponent. An exponent above the requested exponent is stored as the requested exponent.
- R3: Dword 1 is the message address. Bits 1:0 always read 0, and every write request carries 0 in those bits.
- R4: Dword 2 stores a 16-bit message data value in bits 15:0, and bits 31:16 read 0. Bits 31:16 of every write request are 0.
- R5: While the enable is 0, events are dropped. No write request is issued and no pending bit is set.
- R6: With the enable at 1 and exponent x, an event on vector v, where v is unmasked and v < 2^x, produces exactly one write request. Its address is the message address. Its data is the message data with bits x-1:0 replaced by v.
- R7: An event on a vector that is masked (dword 3, bit v) or has v >= 2^x sets bit v of the pending word (dword 4) and issues no write.
- R8: When a pending vector becomes serviceable, because its mask bit is cleared or because the exponent is raised, its message is sent and its pending bit is cleared.
- R9: Software writes to dword 4 have no effect.
- R10: Vectors that are pending together are sent as separate writes, lowest index first.
- R11: wr_valid, wr_addr and wr_data stay stable until wr_ready is seen. The vector's pending bit stays set until that accept and clears with it.
- R12: Further events on a vector whose pending bit is already set merge with it, so only one write is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 3 | Dword index within the capability |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_dw (combinational) |
| evt | input | 32 | One-cycle interrupt event per vector |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Write address (DWORD-aligned) |
| wr_data | output | 32 | Write data (folded message data, zero-extended) |

## Verification
The hardest case to reach is a vector whose pending bit is already set while its own message waits unaccepted on the write port. Only in that window do the merge rule and the hold rule act together. The bench reaches it by raising one event and then holding wr_ready low for several cycles. During the stall it checks that the request is stable and that the pending bit reads as set. It then pulses the same event again, accepts the request, and checks that no second write follows. Deferred release is reached in two ways: by masking a vector and by firing a vector above the enabled count. In each case the bench then clears the mask or raises the exponent and looks for the single write with the folded index.

// File: rtl/msi_pkg.sv
package msi_pkg;

  localparam logic [7:0] MSI_CAP_ID = 8'h05;

  typedef enum logic [2:0] {
    DW_HDR  = 3'd0,
    DW_ADDR = 3'd1,
    DW_DATA = 3'd2,
    DW_MASK = 3'd3,
    DW_PEND = 3'd4
  } cfg_dw_e;

  // Replace the low lg bits of the base data with the vector index.
  function automatic logic [15:0] fold_vec(input logic [15:0] base,
                                           input logic [4:0]  vec,
                                           input logic [2:0]  lg);
    logic [15:0] low;
    low = (16'h1 << lg) - 16'h1;
    return (base & ~low) | ({11'b0, vec} & low);
  endfunction

  // True when the vector index is below 2^lg.
  function automatic logic vec_in_range(input logic [4:0] vec,
                                        input logic [2:0] lg);
    return (({3'b0, vec}) >> lg) == 8'd0;
  endfunction

  // Enabled exponent may not exceed the requested one.
  function automatic logic [2:0] clamp_lg(input logic [2:0] want,
                                          input logic [2:0] limit);
    return (want > limit) ? limit : want;
  endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int          NVEC     = 32,
  parameter int          REQ_LG   = 5,
  parameter bit          MASK_EN  = 1'b1,
  parameter logic [7:0]  NEXT_PTR = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_dw,
  input  logic [31:0]     cfg_wdata,
  input  logic [NVEC-1:0] pend,
  output logic [31:0]     cfg_rdata,
  output logic            msi_en,
  output logic [2:0]      en_lg,
  output logic [31:0]     msg_addr,
  output logic [15:0]     msg_data,
  output logic [NVEC-1:0] vec_mask
);

  localparam logic [2:0] REQ_LG_W = 3'(REQ_LG);

  logic        en_q;
  logic [2:0]  lg_q;
  logic [29:0] addr_q;
  logic [15:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lg_q   <= 3'd0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cfg_wr) begin
      case (cfg_dw)
        DW_HDR: begin
          en_q <= cfg_wdata[16];
          lg_q <= clamp_lg(cfg_wdata[22:20], REQ_LG_W);
        end
        DW_ADDR: addr_q <= cfg_wdata[31:2];
        DW_DATA: data_q <= cfg_wdata[15:0];
        default: ;
      endcase
    end
  end

  generate
    if (MASK_EN) begin : g_mask
      logic [NVEC-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mask_q <= '0;
        else if (cfg_wr && cfg_dw == DW_MASK)
          mask_q <= cfg_wdata[NVEC-1:0];
      end
      assign vec_mask = mask_q;
    end else begin : g_nomask
      assign vec_mask = '0;
    end
  endgenerate

  assign msi_en   = en_q;
  assign en_lg    = lg_q;
  assign msg_addr = {addr_q, 2'b00};
  assign msg_data = data_q;

  always_comb begin
    case (cfg_dw)
      DW_HDR:  cfg_rdata = {7'b0, MASK_EN, 1'b0, lg_q, REQ_LG_W, en_q,
                            NEXT_PTR, MSI_CAP_ID};
      DW_ADDR: cfg_rdata = {addr_q, 2'b00};
      DW_DATA: cfg_rdata = {16'b0, data_q};
      DW_MASK: cfg_rdata = MASK_EN ? 32'(vec_mask) : 32'b0;
      DW_PEND: cfg_rdata = MASK_EN ? 32'(pend) : 32'b0;
      default: cfg_rdata = 32'b0;
    endcase
  end

endmodule

// File: rtl/msi_pend_sched.sv
module msi_pend_sched
  import msi_pkg::*;
#(
  parameter int NVEC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] evt,
  input  logic            msi_en,
  input  logic [2:0]      en_lg,
  input  logic [NVEC-1:0] vec_mask,
  input  logic            busy,
  input  logic            clr_vld,
  input  logic [4:0]      clr_idx,
  output logic [NVEC-1:0] pend,
  output logic            pick_vld,
  output logic [4:0]      pick_idx
);

  logic [NVEC-1:0] pend_q;
  logic [NVEC-1:0] elig;
  logic [NVEC-1:0] clr_vec;
  logic [NVEC-1:0] set_vec;
  logic            found;

  generate
    for (genvar g = 0; g < NVEC; g++) begin : g_elig
      assign elig[g] = pend_q[g] & ~vec_mask[g] & msi_en &
                       vec_in_range(5'(g), en_lg);
      assign clr_vec[g] = clr_vld && (clr_idx == 5'(g));
    end
  endgenerate

  assign set_vec = msi_en ? evt : '0;

  // A fresh event in the accept cycle wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  // Lowest eligible index wins.
  always_comb begin
    found    = 1'b0;
    pick_idx = 5'd0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found    = 1'b1;
        pick_idx = 5'(i);
      end
    end
  end

  assign pick_vld = found & ~busy;
  assign pend     = pend_q;

endmodule

// File: rtl/msi_wr_port.sv
module msi_wr_port
  import msi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pick_vld,
  input  logic [4:0]  pick_idx,
  input  logic [31:0] msg_addr,
  input  logic [15:0] msg_data,
  input  logic [2:0]  en_lg,
  input  logic        wr_ready,
  output logic        wr_valid,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        busy,
  output logic        accept,
  output logic [4:0]  acc_idx
);

  logic        vld_q;
  logic [31:0] addr_q;
  logic [15:0] data_q;
  logic [4:0]  idx_q;

  assign accept = vld_q & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      idx_q  <= '0;
    end else if (pick_vld) begin
      vld_q  <= 1'b1;
      addr_q <= {msg_addr[31:2], 2'b00};
      data_q <= fold_vec(msg_data, pick_idx, en_lg);
      idx_q  <= pick_idx;
    end else if (accept) begin
      vld_q <= 1'b0;
    end
  end

  assign wr_valid = vld_q;
  assign wr_addr  = addr_q;
  assign wr_data  = {16'b0, data_q};
  assign busy     = vld_q;
  assign acc_idx  = idx_q;

endmodule

// File: rtl/msi_gen.sv
module msi_gen
  import msi_pkg::*;
#(
  parameter int         NVEC     = 32,
  parameter int         REQ_LG   = 5,
  parameter bit         MASK_EN  = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_dw,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic [NVEC-1:0] evt,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [31:0]     wr_addr,
  output logic [31:0]     wr_data
);

  logic            msi_en;
  logic [2:0]      en_lg;
  logic [31:0]     msg_addr;
  logic [15:0]     msg_data;
  logic [NVEC-1:0] vec_mask;
  logic [NVEC-1:0] pend;
  logic            pick_vld;
  logic [4:0]      pick_idx;
  logic            busy;
  logic            accept;
  logic [4:0]      acc_idx;

  msi_cfg_regs #(
    .NVEC(NVEC), .REQ_LG(REQ_LG), .MASK_EN(MASK_EN), .NEXT_PTR(NEXT_PTR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .pend(pend), .cfg_rdata(cfg_rdata),
    .msi_en(msi_en), .en_lg(en_lg), .msg_addr(msg_addr),
    .msg_data(msg_data), .vec_mask(vec_mask)
  );

  msi_pend_sched #(.NVEC(NVEC)) u_sched (
    .clk(clk), .rst_n(rst_n), .evt(evt), .msi_en(msi_en), .en_lg(en_lg),
    .vec_mask(vec_mask), .busy(busy), .clr_vld(accept), .clr_idx(acc_idx),
    .pend(pend), .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  msi_wr_port u_port (
    .clk(clk), .rst_n(rst_n), .pick_vld(pick_vld), .pick_idx(pick_idx),
    .msg_addr(msg_addr), .msg_data(msg_data), .en_lg(en_lg),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .accept(accept), .acc_idx(acc_idx)
  );

endmodule

// File: rtl/msi_gen_chk.sv
module msi_gen_chk #(
  parameter int NVEC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            msi_en,
  input logic [NVEC-1:0] evt,
  input logic [NVEC-1:0] pend,
  input logic            accept,
  input logic [4:0]      acc_idx,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [31:0]     wr_addr,
  input logic [31:0]     wr_data
);

  p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00);

  p_data_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[31:16] == 16'h0);

  p_start_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(msi_en));

  p_hold_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid);

  p_hold_payload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ($stable(wr_addr) && $stable(wr_data)));

  p_pend_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !evt[acc_idx]) |=> !pend[$past(acc_idx)]);

  p_inflight_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> pend[acc_idx]);

endmodule

bind msi_gen msi_gen_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .evt(evt), .pend(pend),
  .accept(accept), .acc_idx(acc_idx), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_msi_gen.sv
`timescale 1ns/1ps
module sim_msi_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_dw = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic [31:0] evt = 32'd0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] ADDR = 32'hFEE0_0004;
  localparam logic [15:0] DATA = 16'h1234;

  always #4 clk = ~clk;

  msi_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt(evt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  function automatic logic [31:0] hdr(input bit en, input int lg);
    return 32'h010A_0005 | (32'(en) << 16) | (32'(lg) << 20);
  endfunction

  function automatic logic [31:0] fold(input int v, input int lg);
    int span;
    span = 1 << lg;
    return 32'((int'(DATA) / span) * span + (v % span));
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] dw, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_check(input logic [2:0] dw, input logic [31:0] exp,
                           input string tag);
    @(negedge clk);
    cfg_dw = dw;
    #1;
    check(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = 32'd0;
  endtask

  task automatic take_msg(input logic [31:0] exp_data, input string tag);
    int n;
    n = 0;
    while (!wr_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(wr_valid === 1'b1, {tag, " valid"}, 32'(wr_valid), 32'd1);
    check(wr_addr === ADDR, {tag, " addr"}, wr_addr, ADDR);
    check(wr_data === exp_data, {tag, " data"}, wr_data, exp_data);
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
  endtask

  task automatic no_msg(input int cycles, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wr_valid) seen = 1'b1;
    end
    check(!seen, tag, 32'(seen), 32'd0);
  endtask

  task automatic t_reset;
    cfg_check(3'd0, 32'h010A_0005, "R1 header at reset");
    cfg_check(3'd4, 32'd0, "R1 pending at reset");
    check(wr_valid === 1'b0, "R1 no request at reset", 32'(wr_valid), 32'd0);
  endtask

  task automatic t_config;
    cfg_write(3'd0, 32'hFFFF_FFFF);
    cfg_check(3'd0, hdr(1'b1, 5), "R2 exponent clamped");
    cfg_write(3'd0, 32'h0021_0000);
    cfg_check(3'd0, hdr(1'b1, 2), "R2 enable and exponent");
    cfg_write(3'd1, 32'hFEE0_0007);
    cfg_check(3'd1, ADDR, "R3 address low bits");
    cfg_write(3'd2, 32'hABCD_1234);
    cfg_check(3'd2, 32'h0000_1234, "R4 data width");
  endtask

  task automatic t_disabled;
    cfg_write(3'd0, hdr(1'b0, 2));
    pulse(32'h2);
    no_msg(10, "R5 no write while disabled");
    cfg_check(3'd4, 32'd0, "R5 no pending while disabled");
  endtask

  task automatic t_basic;
    cfg_write(3'd0, hdr(1'b1, 2));
    pulse(32'h8);
    take_msg(fold(3, 2), "R6 vector 3 of 4");
    pulse(32'h1);
    take_msg(fold(0, 2), "R6 vector 0 of 4");
    cfg_write(3'd0, hdr(1'b1, 0));
    pulse(32'h1);
    take_msg(fold(0, 0), "R6 single vector");
    cfg_write(3'd0, hdr(1'b1, 5));
    pulse(32'h8000_0000);
    take_msg(fold(31, 5), "R6 vector 31 of 32");
    no_msg(6, "R6 only one write");
  endtask

  task automatic t_mask;
    cfg_write(3'd3, 32'h10);
    pulse(32'h10);
    no_msg(8, "R7 masked vector silent");
    cfg_check(3'd4, 32'h10, "R7 masked vector pending");
    cfg_write(3'd4, 32'h0);
    cfg_check(3'd4, 32'h10, "R9 pending not writable");
    cfg_write(3'd3, 32'h0);
    take_msg(fold(4, 5), "R8 released on unmask");
    cfg_check(3'd4, 32'd0, "R8 pending cleared");
  endtask

  task automatic t_range;
    cfg_write(3'd0, hdr(1'b1, 2));
    pulse(32'h200);
    no_msg(8, "R7 out-of-range silent");
    cfg_check(3'd4, 32'h200, "R7 out-of-range pending");
    cfg_write(3'd0, hdr(1'b1, 5));
    take_msg(fold(9, 5), "R8 released on wider count");
    cfg_check(3'd4, 32'd0, "R8 pending cleared after range");
  endtask

  task automatic t_prio;
    pulse(32'h0010_0084);
    take_msg(fold(2, 5), "R10 first lowest");
    take_msg(fold(7, 5), "R10 second");
    take_msg(fold(20, 5), "R10 third");
    no_msg(6, "R10 nothing more");
  endtask

  task automatic t_stall;
    logic [31:0] a0;
    logic [31:0] d0;
    bit moved;
    pulse(32'h20);
    @(negedge clk);
    @(negedge clk);
    check(wr_valid === 1'b1, "R11 request raised", 32'(wr_valid), 32'd1);
    a0 = wr_addr;
    d0 = wr_data;
    moved = 1'b0;
    pulse(32'h20);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!wr_valid || wr_addr !== a0 || wr_data !== d0) moved = 1'b1;
    end
    check(!moved, "R11 held while stalled", 32'(moved), 32'd0);
    cfg_check(3'd4, 32'h20, "R11 pending during stall");
    take_msg(fold(5, 5), "R11 stalled payload");
    cfg_check(3'd4, 32'd0, "R11 pending cleared on accept");
    no_msg(8, "R12 repeat event merged");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_disabled();
    t_basic();
    t_mask();
    t_range();
    t_prio();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule